// File: doc/BRIEF.md
# Scratchpad Lane Mixer

This block is one lane of a memory-hard proof-of-work loop. The lane owns a private scratchpad of 64-byte slots and a 256-bit lane state. A run is started from the idle state. It seeds the lane state from a 256-bit header seed, a 32-bit nonce and the lane's own index. It then performs a fixed number of strictly sequential read-modify-write iterations. In each iteration a slot is chosen from the current state and read. The slot is then mixed with the state by a BLAKE3 compression cut down to two rounds. The whole 64-byte result is written back into the same slot, and its first eight words become the new state.

The scratchpad is filled once through a preload port and is never cleared by a run. Many nonces can therefore be tried against the same memory image, and each run inherits the slots left by the run before it. When a run ends, the lane state and the nonce it was started with are presented for a final full-strength hash, which lies outside this block. With the default parameters the lane has 2048 slots (128 KB), an 11-bit slot address and 2048 iterations. Eight such lanes make up a 1 MB working set.

Top module: `lanemix_lane`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are 0, and state_out and nonce_out are all zeros.
- R2: A start sampled while idle raises busy on that edge. The lane then runs exactly ITERS iterations of ROUNDS+3 cycles each. done is high for one single cycle, which follows edge number 1+ITERS*(ROUNDS+3) counted from the start edge (edge 1). busy falls on the same edge.
- R3: An iteration with index i (counting from 0) uses the standard BLAKE3 compression with ROUNDS rounds. The chaining value is the lane state and the message is the slot read. The counter is i (high word 0), the block length is 64 and the flags are 0. Words 0-15 of the output are written to the slot, and words 0-7 become the new lane state.
- R4: The slot used in iteration i is the low ADDR_W bits of state word 0 XOR the low ADDR_W bits of i.
- R5: Each iteration's write completes before the next read is issued. A slot read later in the same run returns the most recently written value.
- R6: Only a preload accepted while idle and the lane's own write-backs change the scratchpad. A new run starts from the contents left by the previous run.
- R7: The initial state is the seed with word 0 XOR nonce and word 7 XOR LANE_IDX. Lanes with different indices, equal seeds and equal scratchpads therefore give different results.
- R8: While idle, pre_we writes pre_data to slot pre_addr. While busy, pre_we is ignored.
- R9: start is ignored while busy. The run in progress neither restarts nor lengthens.
- R10: From done until the next start, state_out and nonce_out hold steady. nonce_out equals the nonce sampled with start.
- R11: Word k of every 256- and 512-bit bus occupies bits 32k+31 down to 32k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| seed | input | 256 | Header-derived seed, eight 32-bit words |
| nonce | input | 32 | Nonce for this run |
| pre_we | input | 1 | Preload write enable (idle only) |
| pre_addr | input | ADDR_W | Preload slot index |
| pre_data | input | 512 | Preload slot contents, sixteen words |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| state_out | output | 256 | Final lane state |
| nonce_out | output | 32 | Nonce the state belongs to |

## Verification
The bench preloads a small scratchpad into two lanes with different indices. It then runs sweeps of seeds and nonces without reloading, so the slot contents carry over from run to run. A design that reinitialised memory, mixed up the slot address XOR, or miscounted the rounds or the counter word would soon produce a state that differs from the bench's arithmetic model. Slots that are read again after an earlier write in the same run are counted, so a missing write-back or a stale read would show up as a wrong state. A start and a preload are injected in the middle of a run. A design that obeyed them would change the latency, corrupt a slot that a later run reads, or restart with the wrong nonce.

// File: rtl/lanemix_pkg.sv
package lanemix_pkg;

  typedef logic [31:0]       word_t;
  typedef logic [15:0][31:0] blk_t;
  typedef logic [7:0][31:0]  cv_t;

  function automatic word_t iv_word(int unsigned i);
    case (i)
      0: return 32'h6A09E667;
      1: return 32'hBB67AE85;
      2: return 32'h3C6EF372;
      3: return 32'hA54FF53A;
      4: return 32'h510E527F;
      5: return 32'h9B05688C;
      6: return 32'h1F83D9AB;
      default: return 32'h5BE0CD19;
    endcase
  endfunction

  function automatic word_t ror32(word_t x, int unsigned n);
    return (x >> n) | (x << (32 - n));
  endfunction

  // quarter-round mixing four state words with two message words
  function automatic blk_t g_fn(blk_t v, int unsigned a, int unsigned b,
                                int unsigned c, int unsigned d, word_t x, word_t y);
    blk_t r = v;
    r[a] = r[a] + r[b] + x;
    r[d] = ror32(r[d] ^ r[a], 16);
    r[c] = r[c] + r[d];
    r[b] = ror32(r[b] ^ r[c], 12);
    r[a] = r[a] + r[b] + y;
    r[d] = ror32(r[d] ^ r[a], 8);
    r[c] = r[c] + r[d];
    r[b] = ror32(r[b] ^ r[c], 7);
    return r;
  endfunction

  // columns first, then diagonals
  function automatic blk_t round_fn(blk_t v, blk_t m);
    blk_t r = v;
    r = g_fn(r, 0, 4,  8, 12, m[0],  m[1]);
    r = g_fn(r, 1, 5,  9, 13, m[2],  m[3]);
    r = g_fn(r, 2, 6, 10, 14, m[4],  m[5]);
    r = g_fn(r, 3, 7, 11, 15, m[6],  m[7]);
    r = g_fn(r, 0, 5, 10, 15, m[8],  m[9]);
    r = g_fn(r, 1, 6, 11, 12, m[10], m[11]);
    r = g_fn(r, 2, 7,  8, 13, m[12], m[13]);
    r = g_fn(r, 3, 4,  9, 14, m[14], m[15]);
    return r;
  endfunction

  function automatic int unsigned perm_src(int unsigned i);
    case (i)
      0: return 2;   1: return 6;   2: return 3;   3: return 10;
      4: return 7;   5: return 0;   6: return 4;   7: return 13;
      8: return 1;   9: return 11; 10: return 12; 11: return 5;
      12: return 9; 13: return 14; 14: return 15; default: return 8;
    endcase
  endfunction

  function automatic blk_t permute_fn(blk_t m);
    blk_t p;
    for (int i = 0; i < 16; i++) p[i] = m[perm_src(i)];
    return p;
  endfunction

  // working state: chaining value, IV head, counter, block length, flags
  function automatic blk_t init_v(cv_t cv, word_t ctr);
    blk_t v;
    for (int i = 0; i < 8; i++) v[i] = cv[i];
    for (int i = 0; i < 4; i++) v[8+i] = iv_word(i);
    v[12] = ctr;
    v[13] = 32'd0;
    v[14] = 32'd64;
    v[15] = 32'd0;
    return v;
  endfunction

  function automatic blk_t finalize(blk_t v, cv_t cv);
    blk_t o;
    for (int i = 0; i < 8; i++) begin
      o[i]   = v[i] ^ v[i+8];
      o[i+8] = v[i+8] ^ cv[i];
    end
    return o;
  endfunction

  function automatic cv_t lane_seed(cv_t seed, word_t nonce, word_t lane);
    cv_t s = seed;
    s[0] = s[0] ^ nonce;
    s[7] = s[7] ^ lane;
    return s;
  endfunction

  function automatic word_t slot_index(word_t w0, word_t iter);
    return w0 ^ iter;
  endfunction

endpackage

// File: rtl/lanemix_spad.sv
module lanemix_spad #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  // history counter so the checks below never look past reset
  logic [1:0] armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              armed <= 2'd0;
    else if (armed != 2'd3)  armed <= armed + 2'd1;
  end

  // R5: a read issued right after a write to the same slot sees the new data
  p_raw_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed == 2'd3 && re && $past(we) && raddr == $past(waddr))
      |=> (rdata == $past(wdata, 2)));

endmodule

// File: rtl/lanemix_comp.sv
module lanemix_comp import lanemix_pkg::*; #(
  parameter int ROUNDS = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  input  cv_t   cv_in,
  input  blk_t  m_in,
  input  word_t ctr,
  output blk_t  out,
  output logic  last
);
  localparam int RW = $clog2(ROUNDS + 1);

  blk_t          v_q;
  blk_t          m_q;
  cv_t           cv_q;
  logic [RW-1:0] rnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      m_q   <= '0;
      cv_q  <= '0;
      rnd_q <= '0;
    end else if (load) begin
      v_q   <= init_v(cv_in, ctr);
      m_q   <= m_in;
      cv_q  <= cv_in;
      rnd_q <= '0;
    end else if (step) begin
      v_q   <= round_fn(v_q, m_q);
      m_q   <= permute_fn(m_q);
      rnd_q <= rnd_q + RW'(1);
    end
  end

  assign out  = finalize(v_q, cv_q);
  assign last = (rnd_q == RW'(ROUNDS - 1));

  // R3: never more than ROUNDS rounds per compression
  p_round_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (rnd_q < RW'(ROUNDS)));
  // R3: load and step are never asked for together
  p_one_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({load, step}) <= 1);

endmodule

// File: rtl/lanemix_lane.sv
module lanemix_lane import lanemix_pkg::*; #(
  parameter int ADDR_W   = 11,
  parameter int ITERS    = 2048,
  parameter int ROUNDS   = 2,
  parameter int LANE_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [255:0]      seed,
  input  logic [31:0]       nonce,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [511:0]      pre_data,
  output logic              busy,
  output logic              done,
  output logic [255:0]      state_out,
  output logic [31:0]       nonce_out
);
  localparam int ITER_W = (ITERS > 1) ? $clog2(ITERS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_LOAD, S_RND, S_WB} st_e;

  st_e               st;
  cv_t               lane_st;
  logic [ITER_W-1:0] iter;
  logic [ADDR_W-1:0] slot_q;
  logic [31:0]       nonce_q;
  logic              done_q;

  // named internal events
  logic              rd_en, comp_load, comp_step, wb_we, pre_acc, mem_we;
  logic              last_iter, comp_last;
  logic [ADDR_W-1:0] rd_addr, mem_waddr;
  blk_t              mem_wdata, slot_rd, comp_out;

  assign last_iter = (iter == ITER_W'(ITERS - 1));
  assign rd_addr   = ADDR_W'(slot_index(lane_st[0], 32'(iter)));
  assign pre_acc   = pre_we && (st == S_IDLE);
  assign mem_we    = pre_acc || wb_we;
  assign mem_waddr = wb_we ? slot_q : pre_addr;
  assign mem_wdata = wb_we ? comp_out : pre_data;

  always_comb begin
    rd_en     = 1'b0;
    comp_load = 1'b0;
    comp_step = 1'b0;
    wb_we     = 1'b0;
    case (st)
      S_ADDR:  rd_en     = 1'b1;
      S_LOAD:  comp_load = 1'b1;
      S_RND:   comp_step = 1'b1;
      S_WB:    wb_we     = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lane_st <= '0;
      iter    <= '0;
      slot_q  <= '0;
      nonce_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          lane_st <= lane_seed(cv_t'(seed), nonce, 32'(LANE_IDX));
          nonce_q <= nonce;
          iter    <= '0;
          st      <= S_ADDR;
        end
        S_ADDR: begin
          slot_q <= rd_addr;
          st     <= S_LOAD;
        end
        S_LOAD: st <= S_RND;
        S_RND:  if (comp_last) st <= S_WB;
        S_WB: begin
          lane_st <= cv_t'(comp_out[7:0]);
          iter    <= iter + ITER_W'(1);
          if (last_iter) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_ADDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  lanemix_spad #(.ADDR_W(ADDR_W), .DATA_W(512)) u_spad (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (slot_rd)
  );

  lanemix_comp #(.ROUNDS(ROUNDS)) u_comp (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (comp_load),
    .step  (comp_step),
    .cv_in (lane_st),
    .m_in  (slot_rd),
    .ctr   (32'(iter)),
    .out   (comp_out),
    .last  (comp_last)
  );

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign state_out = lane_st;
  assign nonce_out = nonce_q;

  // R2: done lasts one cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: done only appears once the lane is idle again
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9: a run only ends at its final write-back, whatever start does
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(st == S_WB && last_iter)) |=> busy);
  // R8: while busy the only scratchpad write is the lane's own write-back
  p_pre_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_we) |-> (st == S_WB));
  // R10: results hold while idle without a start
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(state_out) && $stable(nonce_out)));

endmodule

// File: tb/lanemix_lane_test.sv
module lanemix_lane_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW     = 4;
  localparam int DEPTH  = 1 << AW;
  localparam int ITERS  = 24;
  localparam int ROUNDS = 2;
  localparam int LANE_A = 0;
  localparam int LANE_B = 5;
  localparam int LAT    = 1 + ITERS * (ROUNDS + 3);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [255:0] seed = '0;
  logic [31:0] nonce = '0;
  logic pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [511:0] pre_data = '0;
  logic busy, done, busy_b, done_b;
  logic [255:0] state_a, state_b;
  logic [31:0] nonce_a, nonce_b;

  int n_run = 0;
  int n_fail = 0;
  int unsigned mmem [2][DEPTH][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  lanemix_lane #(.ADDR_W(AW), .ITERS(ITERS), .ROUNDS(ROUNDS), .LANE_IDX(LANE_A)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .nonce(nonce),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .busy(busy), .done(done), .state_out(state_a), .nonce_out(nonce_a));

  lanemix_lane #(.ADDR_W(AW), .ITERS(ITERS), .ROUNDS(ROUNDS), .LANE_IDX(LANE_B)) uut_b (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .nonce(nonce),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .busy(busy_b), .done(done_b), .state_out(state_b), .nonce_out(nonce_b));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rr(int unsigned x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  // reference compression: index tables and a message schedule
  task automatic bcomp(input int unsigned cv[8], input int unsigned msg[16],
                       input int unsigned ctr, output int unsigned o[16]);
    int ga[8] = '{0, 1, 2, 3, 0, 1, 2, 3};
    int gb[8] = '{4, 5, 6, 7, 5, 6, 7, 4};
    int gc[8] = '{8, 9, 10, 11, 10, 11, 8, 9};
    int gd[8] = '{12, 13, 14, 15, 15, 12, 13, 14};
    int pm[16] = '{2, 6, 3, 10, 7, 0, 4, 13, 1, 11, 12, 5, 9, 14, 15, 8};
    int unsigned ivh[4] = '{32'h6A09E667, 32'hBB67AE85, 32'h3C6EF372, 32'hA54FF53A};
    int unsigned v[16];
    int sched[16];
    int nx[16];
    for (int i = 0; i < 8; i++) v[i] = cv[i];
    for (int i = 0; i < 4; i++) v[8+i] = ivh[i];
    v[12] = ctr; v[13] = 0; v[14] = 64; v[15] = 0;
    for (int i = 0; i < 16; i++) sched[i] = i;
    for (int r = 0; r < ROUNDS; r++) begin
      for (int j = 0; j < 8; j++) begin
        int a = ga[j], b = gb[j], c = gc[j], d = gd[j];
        v[a] = v[a] + v[b] + msg[sched[2*j]];
        v[d] = rr(v[d] ^ v[a], 16);
        v[c] = v[c] + v[d];
        v[b] = rr(v[b] ^ v[c], 12);
        v[a] = v[a] + v[b] + msg[sched[2*j+1]];
        v[d] = rr(v[d] ^ v[a], 8);
        v[c] = v[c] + v[d];
        v[b] = rr(v[b] ^ v[c], 7);
      end
      for (int i = 0; i < 16; i++) nx[i] = sched[pm[i]];
      sched = nx;
    end
    for (int i = 0; i < 8; i++) begin
      o[i]   = v[i] ^ v[i+8];
      o[i+8] = v[i+8] ^ cv[i];
    end
  endtask

  // R3 R4 R5 R6 R7: arithmetic model of one run on lane memory ln
  task automatic model_run(input int ln, input logic [255:0] sd, input logic [31:0] nc,
                           input int lid, output logic [255:0] res, inout int reuse);
    int unsigned st[8];
    int unsigned msg[16];
    int unsigned o[16];
    bit wr[DEPTH];
    for (int s = 0; s < DEPTH; s++) wr[s] = 1'b0;
    for (int i = 0; i < 8; i++) st[i] = sd[32*i +: 32];
    st[0] = st[0] ^ nc;
    st[7] = st[7] ^ lid;
    for (int it = 0; it < ITERS; it++) begin
      int a = int'((st[0] ^ it) & (DEPTH - 1));
      if (wr[a]) reuse++;
      for (int k = 0; k < 16; k++) msg[k] = mmem[ln][a][k];
      bcomp(st, msg, it, o);
      for (int k = 0; k < 16; k++) mmem[ln][a][k] = o[k];
      wr[a] = 1'b1;
      for (int k = 0; k < 8; k++) st[k] = o[k];
    end
    for (int i = 0; i < 8; i++) res[32*i +: 32] = st[i];
  endtask

  task automatic preload(input int pat);
    for (int s = 0; s < DEPTH; s++) begin
      @(negedge clk);
      pre_we = 1'b1;
      pre_addr = AW'(s);
      for (int k = 0; k < 16; k++) begin
        int unsigned w = (s * 32'h01000193) ^ (k * 32'h9E3779B9) ^ (pat * 32'h85EBCA6B);
        w = w + k;
        pre_data[32*k +: 32] = w;
        mmem[0][s][k] = w;
        mmem[1][s][k] = w;
      end
    end
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  // start both lanes; inject = stray start and preload mid-run
  task automatic run_both(input logic [255:0] sd, input logic [31:0] nc,
                          input bit inject, output int lat);
    @(negedge clk);
    seed = sd;
    nonce = nc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 4 * LAT) begin
      if (inject && lat == 7) begin
        start = 1'b1;
        nonce = nc ^ 32'hFFFF0000;
        pre_we = 1'b1;
        pre_addr = AW'(2);
        pre_data = '1;
      end
      if (inject && lat == 12) begin
        start = 1'b0;
        pre_we = 1'b0;
        chk(busy == 1'b1, "R9", "busy kept through stray start", 256'(busy), 256'(1));
      end
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic one_run(input logic [255:0] sd, input logic [31:0] nc,
                         input bit inject, input string tag);
    int lat;
    int reuse = 0;
    logic [255:0] ea, eb;
    model_run(0, sd, nc, LANE_A, ea, reuse);
    model_run(1, sd, nc, LANE_B, eb, reuse);
    run_both(sd, nc, inject, lat);
    chk(lat == LAT, "R2", {tag, " latency"}, 256'(lat), 256'(LAT));
    chk(done_b == 1'b1, "R2", {tag, " second lane done together"}, 256'(done_b), 256'(1));
    chk(state_a == ea, "R3", {tag, " lane A final state"}, state_a, ea);
    chk(state_b == eb, "R7", {tag, " lane B final state"}, state_b, eb);
    chk(state_a != state_b, "R7", {tag, " lanes diverge"}, state_a, state_b);
    chk(reuse > 0, "R5", {tag, " rewritten slots reread"}, 256'(reuse), 256'(1));
    chk(nonce_a == nc, "R10", {tag, " nonce_out"}, 256'(nonce_a), 256'(nc));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R2", {tag, " done one cycle"}, 256'({done, busy}), 256'(0));
    repeat (4) @(negedge clk);
    chk(state_a == ea && nonce_a == nc, "R10", {tag, " results hold"}, state_a, ea);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] sd;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", 256'({busy, done}), 256'(0));
    chk(state_a == '0 && nonce_a == '0, "R1", "outputs in reset", state_a, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", 256'({busy, done}), 256'(0));

    // R8 R11: preload while idle, word k at bits 32k+31:32k
    preload(1);
    // R3 R4: first run on fresh memory
    sd = 256'h0123456789ABCDEF_FEDCBA9876543210_0F1E2D3C4B5A6978_8796A5B4C3D2E1F0;
    one_run(sd, 32'h0000_0001, 1'b0, "run1");
    // R6: no reload, next nonce sees memory left by run1
    one_run(sd, 32'h0000_0002, 1'b0, "run2 R6");
    // R8 R9: stray start and preload mid-run; later runs prove memory untouched
    one_run(sd, 32'hDEAD_BEEF, 1'b1, "run3 R8 R9");
    // R4 R6: sweep of nonces and seeds over the carried-over memory
    for (int n = 0; n < 6; n++) begin
      logic [255:0] s2 = sd ^ {8{32'(n * 32'h1234567)}};
      one_run(s2, 32'(n * 32'h10001 + 7), 1'b0, "sweep");
    end
    // R8: a fresh preload replaces the memory image
    preload(9);
    one_run(sd, 32'h0000_0001, 1'b0, "reload");
    one_run('0, 32'h0, 1'b0, "zero seed");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule